// File: doc/BRIEF.md
# Three-Output Clock Source Selector and Divider

This block produces three system clocks from six candidate sources. The three outputs are an auxiliary clock, a subsystem clock and a main clock. The sources are: first crystal, very-low-power oscillator, internal reference, loop oscillator, divided loop oscillator and second crystal. Each output has its own 3-bit source select and its own 3-bit power-of-two divider. A fourth output is a separately divided copy of the auxiliary source, meant for an external pin.

Everything runs on one fast system clock. Each source arrives as a one-cycle enable pulse, one pulse per source edge. Each output is also a one-cycle enable pulse, issued once per divided period of its selected source. The select and divide requests are plain level inputs. An output samples them only when one of its periods ends, so a change never cuts a period short. A control bit masks the subsystem output.

Top module: `clksel_top`

## Requirements
- R1: Source vector bit positions are fixed: bit 0 first crystal, bit 1 very-low-power oscillator, bit 2 internal reference, bit 3 loop oscillator, bit 4 divided loop oscillator, bit 5 second crystal. Select codes 0 to 4 pick bits 0 to 4 in that order.
- R2: Select codes 5, 6 and 7 pick bit 5 when `xt2_present` is 1, and bit 4 when it is 0.
- R3: Divider codes 0 to 5 set a ratio of 1, 2, 4, 8, 16 and 32. An output pulses for one cycle, one cycle after every ratio-th tick of its selected source, counting from the start of a period.
- R4: Divider codes 6 and 7 behave exactly like code 5 (ratio 32).
- R5: `pin_pulse` divides the auxiliary output's selected source with its own code `pin_div`. It uses the R3/R4 table and is independent of `aux_div`.
- R6: While `sub_off` is 1, `sub_pulse` stays 0. The subsystem period count keeps advancing, so a period whose end is masked is lost rather than delayed.
- R7: Reset holds every output at 0. The active settings after reset are: aux source code 0, sub and main source code 4, and all four divider codes 0.
- R8: An output loads a new select or divider request only on the source tick that ends its current period. Ticks inside the current period follow the settings that started it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 6 | Source edge pulses, bit layout per R1 |
| xt2_present | input | 1 | Second crystal is usable |
| aux_sel | input | 3 | Auxiliary source request |
| aux_div | input | 3 | Auxiliary divider request |
| pin_div | input | 3 | Pin-copy divider request |
| sub_sel | input | 3 | Subsystem source request |
| sub_div | input | 3 | Subsystem divider request |
| sub_off | input | 1 | 1 masks the subsystem output |
| main_sel | input | 3 | Main source request |
| main_div | input | 3 | Main divider request |
| aux_pulse | output | 1 | Auxiliary clock enable pulse |
| pin_pulse | output | 1 | Pin-copy clock enable pulse |
| sub_pulse | output | 1 | Subsystem clock enable pulse |
| main_pulse | output | 1 | Main clock enable pulse |

## Verification
Some properties are checked on every cycle:
- every output pulse follows a tick of its selected source;
- period counters stay below their ratio;
- active settings change only when a period ends;
- the subsystem mask holds;
- outputs are quiet as reset releases.

Other behaviour only the directed scenarios can show: the exact source chosen by each of the eight select codes, with and without the second crystal, and the pulse count for each divider code, including the saturated ones. They also cover the independence of the pin divider, the period lost under the mask, and a request taking effect one full period later.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
  localparam int NSRC        = 6;
  localparam int IDXW        = $clog2(NSRC);
  localparam int SELW        = 3;
  localparam int DIVW        = 3;
  localparam int MAXLOG      = 5;
  localparam int CNTW        = MAXLOG;
  localparam int RW          = MAXLOG + 1;
  localparam int NCH         = 3;
  localparam int IDX_LOOPDIV = 4;
  localparam int IDX_XT2     = 5;

  // Divider code to log2 of the ratio, saturating at MAXLOG
  function automatic int div_log2(input logic [DIVW-1:0] code);
    if (int'(code) > MAXLOG) return MAXLOG;
    return int'(code);
  endfunction

  // Last count value of a period (ratio minus one)
  function automatic logic [RW-1:0] div_last(input logic [DIVW-1:0] code);
    logic [RW-1:0] one;
    one = RW'(1);
    return (one << div_log2(code)) - one;
  endfunction

  // Select code to source vector bit; high codes fall back when crystal 2 is absent
  function automatic logic [IDXW-1:0] src_index(input logic [SELW-1:0] code,
                                                input logic xt2_ok);
    if (int'(code) < IDX_XT2) return IDXW'(code);
    if (xt2_ok) return IDXW'(IDX_XT2);
    return IDXW'(IDX_LOOPDIV);
  endfunction
endpackage

// File: rtl/clksel_divider.sv
module clksel_divider
  import clksel_pkg::*;
#(
  parameter logic [DIVW-1:0] DEF_DIV = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            run,
  input  logic [DIVW-1:0] div_req,
  output logic            period_end,
  output logic            pulse
);
  logic [DIVW-1:0] div_act;
  logic [CNTW-1:0] cnt;
  logic [RW-1:0]   last;

  assign last       = div_last(div_act);
  assign period_end = tick && ({1'b0, cnt} == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      div_act <= DEF_DIV;
      pulse   <= 1'b0;
    end else begin
      pulse <= period_end && run;
      if (tick) begin
        if (period_end) begin
          cnt     <= '0;
          div_act <= div_req;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} <= last);

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(div_act));
endmodule

// File: rtl/clksel_channel.sv
module clksel_channel
  import clksel_pkg::*;
#(
  parameter logic [SELW-1:0] DEF_SEL = '0,
  parameter logic [DIVW-1:0] DEF_DIV = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic            xt2_ok,
  input  logic [SELW-1:0] sel_req,
  input  logic [DIVW-1:0] div_req,
  input  logic            run,
  output logic            picked_tick,
  output logic            pulse
);
  logic [SELW-1:0] sel_act;
  logic [IDXW-1:0] idx;
  logic            pend;

  assign idx         = src_index(sel_act, xt2_ok);
  assign picked_tick = src_tick[idx];

  clksel_divider #(.DEF_DIV(DEF_DIV)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (picked_tick),
    .run        (run),
    .div_req    (div_req),
    .period_end (pend),
    .pulse      (pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    sel_act <= DEF_SEL;
    else if (pend) sel_act <= sel_req;
  end

  // R8
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> $stable(sel_act));
endmodule

// File: rtl/clksel_top.sv
module clksel_top
  import clksel_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_tick,
  input  logic            xt2_present,
  input  logic [SELW-1:0] aux_sel,
  input  logic [DIVW-1:0] aux_div,
  input  logic [DIVW-1:0] pin_div,
  input  logic [SELW-1:0] sub_sel,
  input  logic [DIVW-1:0] sub_div,
  input  logic            sub_off,
  input  logic [SELW-1:0] main_sel,
  input  logic [DIVW-1:0] main_div,
  output logic            aux_pulse,
  output logic            pin_pulse,
  output logic            sub_pulse,
  output logic            main_pulse
);
  // Channel order: 0 auxiliary, 1 subsystem, 2 main
  localparam logic [SELW-1:0] DEF_SEL_TBL [NCH] =
    '{SELW'(0), SELW'(IDX_LOOPDIV), SELW'(IDX_LOOPDIV)};

  logic [NCH-1:0][SELW-1:0] sel_req;
  logic [NCH-1:0][DIVW-1:0] div_req;
  logic [NCH-1:0]           run;
  logic [NCH-1:0]           ch_tick;
  logic [NCH-1:0]           ch_pulse;
  logic                     pin_pend;

  assign sel_req = {main_sel, sub_sel, aux_sel};
  assign div_req = {main_div, sub_div, aux_div};
  assign run     = {1'b1, ~sub_off, 1'b1};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    clksel_channel #(
      .DEF_SEL (DEF_SEL_TBL[g]),
      .DEF_DIV (DIVW'(0))
    ) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_tick    (src_tick),
      .xt2_ok      (xt2_present),
      .sel_req     (sel_req[g]),
      .div_req     (div_req[g]),
      .run         (run[g]),
      .picked_tick (ch_tick[g]),
      .pulse       (ch_pulse[g])
    );

    // R1
    tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_pulse[g] |-> $past(ch_tick[g]));
  end

  clksel_divider #(.DEF_DIV(DIVW'(0))) u_pin (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (ch_tick[0]),
    .run        (1'b1),
    .div_req    (pin_div),
    .period_end (pin_pend),
    .pulse      (pin_pulse)
  );

  assign aux_pulse  = ch_pulse[0];
  assign sub_pulse  = ch_pulse[1];
  assign main_pulse = ch_pulse[2];

  // R5
  pin_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pend |-> ch_tick[0]);

  // R6
  sub_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_off |=> !sub_pulse);

  // R7
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !(aux_pulse || pin_pulse || sub_pulse || main_pulse));
endmodule

// File: tb/clksel_top_bench.sv
module clksel_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src = '0;
  logic       xt2_present = 1'b1;
  logic [2:0] aux_sel = '0, aux_div = '0, pin_div = '0;
  logic [2:0] sub_sel = 3'd4, sub_div = '0, main_sel = 3'd4, main_div = '0;
  logic       sub_off = 1'b0;
  logic       aux_pulse, pin_pulse, sub_pulse, main_pulse;

  int n_chk = 0, n_fail = 0;
  int n_aux = 0, n_pin = 0, n_sub = 0, n_main = 0;

  always #10 clk = ~clk;

  clksel_top u_clksel_top (
    .clk(clk), .rst_n(rst_n), .src_tick(src), .xt2_present(xt2_present),
    .aux_sel(aux_sel), .aux_div(aux_div), .pin_div(pin_div),
    .sub_sel(sub_sel), .sub_div(sub_div), .sub_off(sub_off),
    .main_sel(main_sel), .main_div(main_div),
    .aux_pulse(aux_pulse), .pin_pulse(pin_pulse),
    .sub_pulse(sub_pulse), .main_pulse(main_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr();
    n_aux = 0; n_pin = 0; n_sub = 0; n_main = 0;
  endtask

  // One cycle of source ticks; outputs are sampled one edge later
  task automatic step(input logic [5:0] m);
    src = m;
    @(negedge clk);
    src = '0;
    n_aux += int'(aux_pulse); n_pin += int'(pin_pulse);
    n_sub += int'(sub_pulse); n_main += int'(main_pulse);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clr();
  endtask

  function automatic int ratio(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 4;
      3: return 8;  4: return 16; default: return 32;
    endcase
  endfunction

  function automatic int expect_src(input int code, input bit present);
    if (code <= 4) return code;
    return present ? 5 : 4;
  endfunction

  task automatic t_reset();
    aux_sel = 3'd2; aux_div = 3'd3; pin_div = 3'd1;
    sub_sel = 3'd1; sub_div = 3'd2; main_sel = 3'd1; main_div = 3'd3;
    do_reset();
    chk("R7 outputs after reset", int'({aux_pulse, pin_pulse, sub_pulse, main_pulse}), 0);
    step(6'b000001);
    chk("R7 aux default crystal 1 div 1", n_aux, 1);
    chk("R7 pin default div 1", n_pin, 1);
    chk("R7 main ignores crystal 1", n_main, 0);
    step(6'b010000);
    chk("R7 main default divided loop", n_main, 1);
    chk("R7 sub default divided loop", n_sub, 1);
    chk("R7 aux ignores divided loop", n_aux, 1);
  endtask

  task automatic t_select(input bit present);
    xt2_present = present;
    for (int code = 0; code < 8; code++) begin
      main_sel = 3'(code); main_div = '0;
      do_reset();
      step(6'b010000);
      for (int s = 0; s < 6; s++) begin
        clr();
        step(6'(1 << s));
        chk(code <= 4 ? "R1 select map" : "R2 high code fallback",
            n_main, (s == expect_src(code, present)) ? 1 : 0);
      end
    end
    xt2_present = 1'b1;
  endtask

  task automatic t_divide();
    for (int code = 0; code < 8; code++) begin
      main_sel = 3'd3; main_div = 3'(code);
      do_reset();
      step(6'b010000);
      clr();
      for (int i = 0; i < 64; i++) step(6'b001000);
      chk(code <= 5 ? "R3 divide ratio" : "R4 saturated ratio",
          n_main, 64 / ratio(code));
    end
  endtask

  task automatic t_pin();
    aux_sel = 3'd3; aux_div = 3'd1; pin_div = 3'd2;
    do_reset();
    step(6'b000001);
    clr();
    for (int i = 0; i < 64; i++) step(6'b001000);
    chk("R5 aux div 2", n_aux, 32);
    chk("R5 pin div 4", n_pin, 16);
    pin_div = 3'd7;
    do_reset();
    step(6'b000001);
    clr();
    for (int i = 0; i < 64; i++) step(6'b001000);
    chk("R5 pin saturated", n_pin, 2);
    chk("R5 aux unaffected", n_aux, 32);
    aux_sel = '0; aux_div = '0; pin_div = '0;
  endtask

  task automatic t_suboff();
    sub_sel = 3'd3; sub_div = 3'd1; main_sel = 3'd3; main_div = '0;
    do_reset();
    step(6'b010000);
    clr();
    sub_off = 1'b1;
    for (int i = 0; i < 3; i++) step(6'b001000);
    chk("R6 sub masked", n_sub, 0);
    chk("R6 main unaffected", n_main, 3);
    sub_off = 1'b0;
    step(6'b001000);
    chk("R6 count kept running", n_sub, 1);
  endtask

  task automatic t_change();
    main_sel = 3'd3; main_div = 3'd2;
    do_reset();
    step(6'b010000);
    clr();
    main_div = '0;
    for (int i = 0; i < 3; i++) step(6'b001000);
    chk("R8 old div holds", n_main, 0);
    step(6'b001000);
    chk("R8 period completes", n_main, 1);
    step(6'b001000);
    chk("R8 new div applied", n_main, 2);
    main_sel = 3'd1;
    step(6'b000010);
    chk("R8 old source holds", n_main, 2);
    step(6'b001000);
    chk("R8 last old-source period", n_main, 3);
    step(6'b000010);
    chk("R8 new source applied", n_main, 4);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_select(1'b1);
    t_select(1'b0);
    t_divide();
    t_pin();
    t_suboff();
    t_change();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule